// File: doc/BRIEF.md
# Shadowed Control Register Bank

This block holds a small set of configuration registers in which every bit has two copies: a persistent cell that survives power loss and a working cell that actually drives the configuration outputs. After a power-on reset, the block fills the working cells from the persistent cells one register per clock. Only then does it raise `cfgValid`. The persistent storage is modelled as a register array that the reset does not clear. Programming it is modelled as a fixed latency.

A serial-bus front end presents a register address, a write strobe and a data byte. Reads are combinational on the same address. A mode input, which comes from a neighbouring configuration register, sets where a bank write goes. With the mode set, the write goes to both copies. With the mode clear, it goes to the working copy only. With the mode clear, a write to either of two trigger addresses outside the bank reloads every working cell from its persistent cell. An active-low write-protect pin blocks all writes to the bank and blocks that reload. Read-back always shows the persistent copy.

Top module: `shadow_cfg_bank`

## Requirements
- R1: After `porRstN` is released, each working register is copied from its persistent cell, one register per clock in rising address order. During this copy `cfgValid` is low. `cfgValid` rises after exactly NUM_REGS clock edges. Before the copy, `cfgOut` is all zero.
- R2: `cfgOut` carries only the working cells. The register at address BANK_BASE+k sits in bits [k*DATA_W +: DATA_W].
- R3: An accepted bank write with `persistMode`=1 updates the working cell on the next edge. It then holds `busy` high for exactly NV_WR_CYC cycles. After that, the persistent cell holds the written byte. Until then, read-back shows the old persistent value.
- R4: An accepted bank write with `persistMode`=0 updates only the working cell. `busy` stays low, and read-back keeps the old persistent value.
- R5: `rdData` is combinational. When `regSel` selects a bank register, it equals that register's persistent cell. For any other address it is zero.
- R6: With `persistMode`=0 and `wpN`=1, and with the block idle, a strobe to either trigger address (TRIG_ADDR_A or TRIG_ADDR_B) starts a reload of all working cells from the persistent cells. During the reload `cfgValid` is low for NUM_REGS cycles. The data byte is ignored.
- R7: With `persistMode`=1, a strobe to a trigger address leaves the working cells, the persistent cells and `cfgValid` unchanged.
- R8: While `wpN` is 0, a bank write has no effect on either copy and `wrNak` is high in the strobe cycle. A trigger write does not start a reload.
- R9: While `busy` is high or a reload is running, a bank write is refused with `wrNak` high and has no effect. A trigger write is ignored. `wrNak` is low for every accepted write and for every non-bank address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| wrStb | input | 1 | Write strobe from the bus front end |
| regSel | input | ADDR_W | Register address for writes and reads |
| wrData | input | DATA_W | Write data byte |
| wpN | input | 1 | Write protect, active low |
| persistMode | input | 1 | 1: bank writes reach both copies; 0: working copy only, trigger addresses reload |
| wrNak | output | 1 | Bank write refused (combinational, strobe cycle) |
| busy | output | 1 | Persistent programming in progress |
| rdData | output | DATA_W | Persistent copy of the addressed bank register |
| cfgOut | output | NUM_REGS*DATA_W | Working register values |
| cfgValid | output | 1 | Working registers loaded, no reload running |

## Verification
The bench uses the default layout: four byte-wide registers at addresses 1 to 4, with trigger addresses 0 and 5, on a 4-bit address. It shortens the programming latency NV_WR_CYC to 5 cycles, so a refused write can be placed inside the busy window and the exact busy length can still be counted cheaply. It also sets a distinct non-zero persistent image, so the power-up copy and the reload can be told apart from the cleared reset state and from each other. The random address range 0 to 7 reaches both trigger addresses, every bank register and addresses that decode to nothing.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PROG   = 2'd2
  } bankState_e;

  typedef struct packed {
    logic loadWork;   // write wrData into the addressed working cell
    logic latchPend;  // capture address and data for persistent programming
    logic recallEn;   // copy persistent cell recallIdx into its working cell
    logic commitNv;   // programming latency elapsed, store the pending byte
  } ctrlStrobes_t;

endpackage

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int ADDR_W      = 4,
  parameter int BANK_BASE   = 1,
  parameter int TRIG_ADDR_A = 0,
  parameter int TRIG_ADDR_B = 5,
  parameter int NV_WR_CYC   = 16,
  localparam int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int CNT_W      = $clog2(NV_WR_CYC + 1)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wpN,
  input  logic              persistMode,
  output ctrlStrobes_t      strobe,
  output logic [IDX_W-1:0]  bankIdx,
  output logic [IDX_W-1:0]  recallIdx,
  output logic              bankHit,
  output logic              wrNak,
  output logic              busy,
  output logic              cfgValid
);

  bankState_e       state;
  logic [CNT_W-1:0] progCnt;
  logic             trigHit;
  logic             isIdle;
  logic             bankGo;
  logic             trigGo;

  // address decode
  assign bankHit = (int'(regSel) >= BANK_BASE) && (int'(regSel) < BANK_BASE + NUM_REGS);
  assign trigHit = (regSel == ADDR_W'(TRIG_ADDR_A)) || (regSel == ADDR_W'(TRIG_ADDR_B));
  assign bankIdx = IDX_W'(regSel - ADDR_W'(BANK_BASE));

  assign isIdle = (state == ST_IDLE);
  assign bankGo = wrStb && bankHit && isIdle && wpN;
  assign trigGo = wrStb && trigHit && !persistMode && wpN && isIdle;
  assign wrNak  = wrStb && bankHit && (!isIdle || !wpN);

  assign busy     = (state == ST_PROG);
  assign cfgValid = (state != ST_RECALL);

  always_comb begin
    strobe           = '0;
    strobe.loadWork  = bankGo;
    strobe.latchPend = bankGo && persistMode;
    strobe.recallEn  = (state == ST_RECALL);
    strobe.commitNv  = (state == ST_PROG) && (progCnt == '0);
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      state     <= ST_RECALL;
      recallIdx <= '0;
      progCnt   <= '0;
    end else begin
      case (state)
        ST_RECALL: begin
          if (recallIdx == IDX_W'(NUM_REGS - 1)) begin
            state     <= ST_IDLE;
            recallIdx <= '0;
          end else begin
            recallIdx <= recallIdx + 1'b1;
          end
        end
        ST_IDLE: begin
          if (bankGo && persistMode) begin
            state   <= ST_PROG;
            progCnt <= CNT_W'(NV_WR_CYC - 1);
          end else if (trigGo) begin
            state     <= ST_RECALL;
            recallIdx <= '0;
          end
        end
        ST_PROG: begin
          if (progCnt == '0) state <= ST_IDLE;
          else               progCnt <= progCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PERSIST_SETS_BUSY: assert property (@(posedge clk) disable iff (!porRstN)
    (wrStb && bankHit && wpN && persistMode && !wrNak) |=> busy) else $error("persistent write did not start programming"); // R3

  AST_TRIGGER_STARTS_RECALL: assert property (@(posedge clk) disable iff (!porRstN)
    (wrStb && trigHit && !persistMode && wpN && isIdle) |=> !cfgValid) else $error("trigger write did not start reload"); // R6

  AST_REFUSED_NO_PROGRAM: assert property (@(posedge clk) disable iff (!porRstN)
    (wrNak && !busy) |=> !busy) else $error("refused write started programming"); // R9

endmodule

// File: rtl/shadow_cfg_dp.sv
module shadow_cfg_dp
  import shadow_cfg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_REGS = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] NV_INIT = '0,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  ctrlStrobes_t               strobe,
  input  logic [IDX_W-1:0]           wrIdx,
  input  logic [IDX_W-1:0]           recallIdx,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       rdHit,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] cfgOut
);

  logic [DATA_W-1:0] nvArr   [NUM_REGS];
  logic [DATA_W-1:0] workArr [NUM_REGS];
  logic [IDX_W-1:0]  pendIdx;
  logic [DATA_W-1:0] pendData;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pendIdx  <= '0;
      pendData <= '0;
    end else if (strobe.latchPend) begin
      pendIdx  <= wrIdx;
      pendData <= wrData;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_cell
    // persistent cell: untouched by reset, keeps its content across power-on
    logic [DATA_W-1:0] nvCell = NV_INIT[k*DATA_W +: DATA_W];
    logic [DATA_W-1:0] workCell;

    always_ff @(posedge clk) begin
      if (strobe.commitNv && (pendIdx == IDX_W'(k))) nvCell <= pendData;
    end

    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN)                                         workCell <= '0;
      else if (strobe.recallEn && (recallIdx == IDX_W'(k))) workCell <= nvCell;
      else if (strobe.loadWork && (wrIdx == IDX_W'(k)))     workCell <= wrData;
    end

    assign nvArr[k]   = nvCell;
    assign workArr[k] = workCell;
    assign cfgOut[k*DATA_W +: DATA_W] = workCell;
  end

  assign rdData = rdHit ? nvArr[wrIdx] : '0;

  AST_RECALL_COPIES: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.recallEn |=> (workArr[$past(recallIdx)] == $past(nvArr[recallIdx]))) else $error("reload copied wrong value"); // R1

  AST_COMMIT_STORES: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.commitNv |=> (nvArr[$past(pendIdx)] == $past(pendData))) else $error("programming stored wrong value"); // R3

endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
  import shadow_cfg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 4,
  parameter int ADDR_W      = 4,
  parameter int BANK_BASE   = 1,
  parameter int TRIG_ADDR_A = 0,
  parameter int TRIG_ADDR_B = 5,
  parameter int NV_WR_CYC   = 16,
  parameter logic [NUM_REGS*DATA_W-1:0] NV_INIT = '0,
  localparam int IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       porRstN,
  input  logic                       wrStb,
  input  logic [ADDR_W-1:0]          regSel,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       wpN,
  input  logic                       persistMode,
  output logic                       wrNak,
  output logic                       busy,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] cfgOut,
  output logic                       cfgValid
);

  ctrlStrobes_t     strobe;
  logic [IDX_W-1:0] bankIdx;
  logic [IDX_W-1:0] recallIdx;
  logic             bankHit;

  shadow_cfg_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE),
    .TRIG_ADDR_A(TRIG_ADDR_A), .TRIG_ADDR_B(TRIG_ADDR_B), .NV_WR_CYC(NV_WR_CYC)
  ) ctrl_i (
    .clk(clk), .porRstN(porRstN), .wrStb(wrStb), .regSel(regSel),
    .wpN(wpN), .persistMode(persistMode), .strobe(strobe),
    .bankIdx(bankIdx), .recallIdx(recallIdx), .bankHit(bankHit),
    .wrNak(wrNak), .busy(busy), .cfgValid(cfgValid)
  );

  shadow_cfg_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NV_INIT(NV_INIT)
  ) dp_i (
    .clk(clk), .porRstN(porRstN), .strobe(strobe), .wrIdx(bankIdx),
    .recallIdx(recallIdx), .wrData(wrData), .rdHit(bankHit),
    .rdData(rdData), .cfgOut(cfgOut)
  );

  AST_PROTECT_HOLDS_WORK: assert property (@(posedge clk) disable iff (!porRstN)
    (!wpN && cfgValid) |=> $stable(cfgOut)) else $error("working cells changed under write protect"); // R8

endmodule

// File: tb/shadow_cfg_bank_tb_top.sv
module shadow_cfg_bank_tb_top;

  localparam int DW = 8, NR = 4, AW = 4, BASE = 1, TA = 0, TB = 5, NVC = 5;
  localparam logic [NR*DW-1:0] NVI = 32'hC35A_961E;

  logic clk = 1'b0, porRstN = 1'b0, wrStb = 1'b0, wpN = 1'b1, persistMode = 1'b0;
  logic [AW-1:0] regSel = '0;
  logic [DW-1:0] wrData = '0;
  logic wrNak, busy, cfgValid;
  logic [DW-1:0] rdData;
  logic [NR*DW-1:0] cfgOut;

  int checks = 0, errors = 0;
  logic [DW-1:0] expNv [NR];
  logic [DW-1:0] expWork [NR];

  always #10 clk = ~clk;

  shadow_cfg_bank #(
    .DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW), .BANK_BASE(BASE),
    .TRIG_ADDR_A(TA), .TRIG_ADDR_B(TB), .NV_WR_CYC(NVC), .NV_INIT(NVI)
  ) dut_i (
    .clk(clk), .porRstN(porRstN), .wrStb(wrStb), .regSel(regSel), .wrData(wrData),
    .wpN(wpN), .persistMode(persistMode), .wrNak(wrNak), .busy(busy),
    .rdData(rdData), .cfgOut(cfgOut), .cfgValid(cfgValid)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit isBank(int a);
    return (a >= BASE) && (a < BASE + NR);
  endfunction

  function automatic bit isTrig(int a);
    return (a == TA) || (a == TB);
  endfunction

  // R2 / R5: compare working outputs and read-back of every bank register
  task automatic checkState(string req);
    for (int k = 0; k < NR; k++) begin
      chk(req, "cfgOut", cfgOut[k*DW +: DW], expWork[k]);
      regSel = AW'(BASE + k);
      #1;
      chk(req, "rdData", rdData, expNv[k]);
    end
  endtask

  task automatic doWrite(int a, logic [DW-1:0] d, bit m, bit wp, bit busyNow, bit waitDone);
    bit accBank, accTrig;
    int n;
    string req;
    @(negedge clk);
    regSel = AW'(a); wrData = d; persistMode = m; wpN = wp; wrStb = 1'b1;
    #1;
    accBank = isBank(a) && wp && !busyNow;
    accTrig = isTrig(a) && !m && wp && !busyNow;
    req = !wp ? "R8" : busyNow ? "R9" : isTrig(a) ? (m ? "R7" : "R6") : m ? "R3" : "R4";
    chk(req, "wrNak", wrNak, isBank(a) && (!wp || busyNow));
    @(negedge clk);
    wrStb = 1'b0; wpN = 1'b1;
    if (accBank) expWork[a - BASE] = d;
    if (accBank && m) chk("R3", "busy after write", busy, 1'b1);
    else if (!busyNow) chk(accBank ? "R4" : req, "busy", busy, 1'b0);
    if (isTrig(a) && !accTrig) chk(req, "cfgValid kept", cfgValid, 1'b1);
    if (!accTrig) checkState(req);
    if (accBank && m && waitDone) begin
      n = 0;
      while (busy && n < 100) begin @(negedge clk); n++; end
      chk("R3", "busy length", n, NVC);
      expNv[a - BASE] = d;
      checkState("R3");
    end
    if (accTrig) begin
      chk("R6", "cfgValid low", cfgValid, 1'b0);
      n = 0;
      while (!cfgValid && n < 100) begin @(negedge clk); n++; end
      chk("R6", "reload length", n, NR);
      for (int k = 0; k < NR; k++) expWork[k] = expNv[k];
      checkState("R6");
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NR; k++) begin
      expNv[k] = NVI[k*DW +: DW];
      expWork[k] = NVI[k*DW +: DW];
    end

    // R1: reset state and power-up copy
    repeat (3) @(negedge clk);
    chk("R1", "cfgValid in reset", cfgValid, 1'b0);
    chk("R1", "cfgOut in reset", cfgOut, '0);
    chk("R9", "busy in reset", busy, 1'b0);
    porRstN = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!cfgValid && n < 50);
    chk("R1", "power-up copy length", n, NR);
    checkState("R1");

    // R5: non-bank addresses read zero
    regSel = AW'(TA); #1; chk("R5", "rdData addr 0", rdData, 0);
    regSel = AW'(6);  #1; chk("R5", "rdData addr 6", rdData, 0);

    // directed: volatile write then reload restores persistent value
    doWrite(2, 8'hAB, 1'b0, 1'b1, 1'b0, 1'b1);     // R4
    doWrite(TB, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);    // R7 no reload
    doWrite(TA, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1);    // R6 reload
    // write protect blocks writes and reload
    doWrite(3, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1);     // R8
    doWrite(TB, 8'h22, 1'b0, 1'b0, 1'b0, 1'b1);    // R8
    // persistent write, then refused write and trigger during busy
    doWrite(4, 8'h5C, 1'b1, 1'b1, 1'b0, 1'b0);     // R3 start
    doWrite(1, 8'h77, 1'b1, 1'b1, 1'b1, 1'b1);     // R9 refused
    doWrite(TA, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);    // R9 trigger ignored
    n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    expNv[3] = 8'h5C;
    checkState("R3");
    // refused write during reload
    @(negedge clk);
    regSel = AW'(TB); wrData = 8'h00; persistMode = 1'b0; wrStb = 1'b1;
    @(negedge clk);
    regSel = AW'(2); wrData = 8'h99; #1;
    chk("R9", "wrNak during reload", wrNak, 1'b1);
    @(negedge clk);
    wrStb = 1'b0;
    n = 0;
    while (!cfgValid && n < 100) begin @(negedge clk); n++; end
    for (int k = 0; k < NR; k++) expWork[k] = expNv[k];
    checkState("R9");

    // random mix
    for (int i = 0; i < 150; i++) begin
      int a;
      logic [DW-1:0] d;
      bit m, wp;
      a  = int'($urandom % 8);
      d  = DW'($urandom);
      m  = bit'($urandom % 2);
      wp = ($urandom % 4) != 0;
      doWrite(a, d, m, wp, 1'b0, 1'b1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule